// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. Software picks a prescaler and a coarse reload value, then enables the timer. A prescaled down-counter then runs toward zero. Software must keep writing one fixed magic word to the restart register so that the count starts again before it reaches zero. If software stops doing so, the block flags the expiry. It then either raises a level interrupt or drives a reset pulse of programmable length.

Each write that changes behaviour must carry a key. A mode write is accepted only if it holds the mode key, and a counter-control write only if it holds the control key. A restart takes effect only if the whole written word equals the magic value. Stray or corrupted writes therefore cannot stop, retune or feed the timer. The reload field sets only the upper bits of the down-counter. On every load, the lower FINE_W bits are filled with ones.

Top module: `keyed_wdt`

## Requirements
- R1: After reset both outputs are low. The mode register reads 0x0. The control register reads 0x3FFF (reload field all ones, prescaler select 3). The status register reads 0x0.
- R2: A write to word 0 (mode) is stored only when data bits 23:12 equal 0xABC. The stored fields are: bit 0 run, bit 1 reset-out enable, bit 2 interrupt enable, bits 5:4 pulse length. On read the key bits and all other bits return zero. A keyless write leaves a running timer untouched.
- R3: A write to word 1 (control) is stored only when data bits 23:16 equal 0x92. The stored fields are bits 13:2 (12-bit reload) and bits 1:0 (prescaler select). They read back in the same positions, with the key bits reading as zero.
- R4: Writing exactly 0x00001999 to word 2 reloads the counter. Any other value written to word 2 changes neither the pending timeout nor the status.
- R5: The counter loads (reload+1)·2^FINE_W − 1 on a restart and on the write that sets run while run was clear. The prescaler phase restarts on that load. The counter then steps once every 8, 64, 512 or 4096 clock cycles for select values 0, 1, 2 and 3. Expiry becomes visible exactly load_value × divisor cycles after the loading write is captured.
- R6: Status bit 0 (word 3) sets at expiry and stays set. A valid restart clears it, and so does clearing run.
- R7: If reset-out is enabled at expiry, the reset output goes high in the same cycle the status sets. It stays high for 2, 4, 8 or 16 cycles for pulse-length codes 0, 1, 2 and 3.
- R8: The interrupt output is high exactly while status is set, run is set, interrupt enable is set and reset-out enable is clear.
- R9: While run is clear both outputs stay low and status reads zero. Setting run again starts a complete fresh timeout.
- R10: Word 2 always reads zero.
- R11: Read data is registered. It updates on the clock edge that samples the read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_rd | input | 1 | Read strobe, one cycle per transfer |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_o | output | 1 | Timeout reset pulse |
| wdt_irq_o | output | 1 | Timeout interrupt level |

## Verification
The assertions assume single-cycle strobes and word-aligned addresses. They also assume the prescaler select is not changed while the timer runs. Under those conditions, a count that only falls between loads means that any step up comes from an accepted key. The bench keeps to these conditions in three ways. Every transfer is a one-cycle strobe issued at a falling edge. Read and write strobes are never raised together. The control register is rewritten only after run has been cleared.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int BUS_W = 32;
  localparam int PRE_W = 12;
  localparam int RLD_W = 12;
  localparam int PLS_W = 5;

  localparam logic [11:0]      MODE_KEY  = 12'hABC;
  localparam logic [7:0]       CTRL_KEY  = 8'h92;
  localparam logic [BUS_W-1:0] KICK_WORD = 32'h0000_1999;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_CTRL = 2'd1,
    REG_KICK = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } mode_t;

  typedef struct packed {
    logic [RLD_W-1:0] reload;
    logic [1:0]       psel;
  } ctrl_t;

  // last prescaler phase before a tick, per select code
  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] psel);
    case (psel)
      2'd0:    return 12'd7;
      2'd1:    return 12'd63;
      2'd2:    return 12'd511;
      default: return 12'd4095;
    endcase
  endfunction

  // reset pulse width in cycles: 2 << code
  function automatic logic [PLS_W-1:0] pulse_cycles(input logic [1:0] plen);
    return 5'd2 << plen;
  endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [BUS_W-1:0]  rdata,
  input  logic              expire_i,
  output mode_t             mode_o,
  output ctrl_t             ctrl_o,
  output logic              load_o,
  output logic              irq_o
);
  localparam int IDX_LSB = 2;

  mode_t mode_q;
  ctrl_t ctrl_q;
  logic  status_q;

  logic [1:0] idx;
  logic       in_range;
  logic       mode_we, ctrl_we, kick_hit, run_rise;
  logic       unused_addr;

  assign idx         = addr[IDX_LSB +: 2];
  assign in_range    = (addr >> 4) == '0;
  assign unused_addr = ^addr[1:0];

  assign mode_we  = wr && in_range && (idx == REG_MODE) && (wdata[23:12] == MODE_KEY);
  assign ctrl_we  = wr && in_range && (idx == REG_CTRL) && (wdata[23:16] == CTRL_KEY);
  assign kick_hit = wr && in_range && (idx == REG_KICK) && (wdata == KICK_WORD);
  assign run_rise = mode_we && wdata[0] && !mode_q.run;
  assign load_o   = run_rise || kick_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= '{plen: wdata[5:4], irq_en: wdata[2], rst_en: wdata[1], run: wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{reload: '1, psel: 2'd3};
    end else if (ctrl_we) begin
      ctrl_q <= '{reload: wdata[2 +: RLD_W], psel: wdata[1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (!mode_q.run || load_o) begin
      status_q <= 1'b0;
    end else if (expire_i) begin
      status_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (!in_range) begin
        rdata <= '0;
      end else begin
        unique case (reg_sel_e'(idx))
          REG_MODE: rdata <= {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.run};
          REG_CTRL: rdata <= {18'd0, ctrl_q.reload, ctrl_q.psel};
          REG_KICK: rdata <= '0;
          REG_STAT: rdata <= {31'd0, status_q};
        endcase
      end
    end
  end

  assign mode_o = mode_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = status_q && mode_q.run && mode_q.irq_en && !mode_q.rst_en;

  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && mode_q.run && !load_o) |=> status_q);

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && mode_q.run && !load_o && !mode_we) |=> status_q);
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       load_i,
  input  logic [1:0] psel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = div_last(psel_i);
  assign tick_o = run_i && !load_i && (pre_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
    end else if (run_i) begin
      if (pre_q == lim) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
    end
  end

  // R9
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(pre_q));
endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown
  import kwdt_pkg::*;
#(
  parameter int FINE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             expire_o
);
  localparam int CNT_W = RLD_W + FINE_W;

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] load_value(input logic [RLD_W-1:0] rl);
    return {rl, {FINE_W{1'b1}}};
  endfunction

  assign expire_o = tick_i && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_value(reload_i);
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       fire_i,
  input  logic [1:0] plen_i,
  output logic       pulse_o
);
  logic [PLS_W-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!run_i) begin
      pcnt_q <= '0;
    end else if (fire_i) begin
      pcnt_q <= pulse_cycles(plen_i);
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign pulse_o = (pcnt_q != '0);

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire_i));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);
  mode_t mode;
  ctrl_t ctrl;
  logic  load_evt, tick_evt, expire_evt, fire_evt;

  kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .rdata    (bus_rdata),
    .expire_i (expire_evt),
    .mode_o   (mode),
    .ctrl_o   (ctrl),
    .load_o   (load_evt),
    .irq_o    (wdt_irq_o)
  );

  kwdt_prescale u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (mode.run),
    .load_i (load_evt),
    .psel_i (ctrl.psel),
    .tick_o (tick_evt)
  );

  kwdt_countdown #(.FINE_W(FINE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_evt),
    .tick_i   (tick_evt),
    .reload_i (ctrl.reload),
    .expire_o (expire_evt)
  );

  assign fire_evt = expire_evt && mode.rst_en;

  kwdt_pulse u_pls (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (mode.run),
    .fire_i  (fire_evt),
    .plen_i  (mode.plen),
    .pulse_o (wdt_rst_o)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.run |=> (!wdt_rst_o && !wdt_irq_o));
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW         = 2;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o, wdt_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  keyed_wdt #(.ADDR_W(4), .FINE_W(FW)) u_keyed_wdt (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rd,
    .bus_rdata, .wdt_rst_o, .wdt_irq_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  localparam logic [31:0] MK = 32'h00AB_C000;
  localparam logic [31:0] CK = 32'h0092_0000;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic int tmo(input int rl, input int ps);
    int dv;
    dv = 8 << (3 * ps);
    return (((rl + 1) << FW) - 1) * dv;
  endfunction

  task automatic wait_irq(input int c0, output int d);
    while (!wdt_irq_o && (cyc - c0) < LIMIT) @(negedge clk);
    d = cyc - c0;
  endtask

  task automatic wait_rst(input int c0, output int d);
    while (!wdt_rst_o && (cyc - c0) < LIMIT) @(negedge clk);
    d = cyc - c0;
  endtask

  task automatic arm(input int rl, input int ps, input logic [31:0] mbits, output int c0);
    wr(4'h0, MK);
    wr(4'h4, CK | (32'(rl) << 2) | 32'(ps));
    wr(4'h0, MK | mbits | 32'h1);
    c0 = cyc;
  endtask

  initial begin
    logic [31:0] v;
    int c0, d, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rst_o", {31'd0, wdt_rst_o}, 0);
    check("R1 irq_o", {31'd0, wdt_irq_o}, 0);
    rd(4'h0, v); check("R1 mode", v, 32'h0);
    rd(4'h4, v); check("R1 ctrl", v, 32'h3FFF);
    rd(4'hC, v); check("R1 stat", v, 32'h0);
    rd(4'h8, v); check("R10 kick reads zero", v, 32'h0);

    // R2 key gate on mode
    wr(4'h0, 32'h00AB_B036);
    rd(4'h0, v); check("R2 bad key ignored", v, 32'h0);
    wr(4'h0, MK | 32'hFF00_0036);
    rd(4'h0, v); check("R2 fields stored", v, 32'h36);
    wr(4'h0, MK);

    // R3 key gate on control
    wr(4'h4, 32'h0093_0015);
    rd(4'h4, v); check("R3 bad key ignored", v, 32'h3FFF);
    wr(4'h4, CK | 32'h0000_2A15);
    rd(4'h4, v); check("R3 fields stored", v, 32'h2A15);

    // R11 read data holds without a read strobe
    wr(4'h4, CK | 32'h0000_0005);
    check("R11 rdata held", bus_rdata, 32'h2A15);

    // R5 sweep of reload and prescaler
    for (int ps = 0; ps < 2; ps++) begin
      for (int rl = 0; rl < 8; rl++) begin
        arm(rl, ps, 32'h4, c0);
        wait_irq(c0, d);
        check($sformatf("R5 timeout rl=%0d ps=%0d", rl, ps), d, tmo(rl, ps));
      end
    end
    for (int ps = 2; ps < 4; ps++) begin
      arm(0, ps, 32'h4, c0);
      wait_irq(c0, d);
      check($sformatf("R5 timeout ps=%0d", ps), d, tmo(0, ps));
    end

    // R6 sticky status, cleared by restart
    repeat (40) @(negedge clk);
    check("R6 irq still set", {31'd0, wdt_irq_o}, 1);
    rd(4'hC, v); check("R6 status sticky", v, 32'h1);
    wr(4'h8, 32'h0000_1999);
    check("R6 irq cleared by restart", {31'd0, wdt_irq_o}, 0);
    rd(4'hC, v); check("R6 status cleared by restart", v, 32'h0);

    // R4 good restart extends timeout
    arm(1, 0, 32'h4, c0);
    repeat (20) @(negedge clk);
    wr(4'h8, 32'h0000_1999);
    c0 = cyc;
    wait_irq(c0, d); check("R4 restart reloads", d, tmo(1, 0));

    // R4 wrong restart word ignored
    arm(1, 0, 32'h4, c0);
    repeat (20) @(negedge clk);
    wr(4'h8, 32'h0000_1998);
    wait_irq(c0, d); check("R4 bad word ignored", d, tmo(1, 0));

    // R2 keyless stop attempt ignored while running
    arm(1, 0, 32'h4, c0);
    repeat (10) @(negedge clk);
    wr(4'h0, 32'h0000_0000);
    wait_irq(c0, d); check("R2 keyless stop ignored", d, tmo(1, 0));

    // R6 R9 disable clears status, quiets outputs, restarts fully
    wr(4'h0, MK);
    check("R9 irq low when stopped", {31'd0, wdt_irq_o}, 0);
    rd(4'hC, v); check("R6 status cleared by stop", v, 32'h0);
    arm(1, 0, 32'h4, c0);
    repeat (30) @(negedge clk);
    wr(4'h0, MK | 32'h4);
    repeat (100) @(negedge clk);
    check("R9 outputs quiet", {30'd0, wdt_rst_o, wdt_irq_o}, 0);
    rd(4'hC, v); check("R9 status zero", v, 32'h0);
    wr(4'h0, MK | 32'h5);
    c0 = cyc;
    wait_irq(c0, d); check("R9 fresh timeout", d, tmo(1, 0));

    // R8 no interrupt when interrupt enable is clear
    arm(0, 0, 32'h0, c0);
    repeat (tmo(0, 0) + 10) @(negedge clk);
    check("R8 irq masked", {31'd0, wdt_irq_o}, 0);
    rd(4'hC, v); check("R8 status set while masked", v, 32'h1);

    // R7 reset pulse widths, R8 interrupt suppressed by reset-out
    for (int pl = 0; pl < 4; pl++) begin
      arm(0, 0, 32'h6 | (32'(pl) << 4), c0);
      wait_rst(c0, d);
      check($sformatf("R7 pulse start pl=%0d", pl), d, tmo(0, 0));
      check("R8 irq off with reset-out", {31'd0, wdt_irq_o}, 0);
      w = 0;
      while (wdt_rst_o && w < 100) begin @(negedge clk); w++; end
      check($sformatf("R7 pulse width pl=%0d", pl), w, 2 << pl);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule